// File: doc/BRIEF.md
# Machine Status Word with Supervisor Alias

This block keeps the machine status word of a small RV32-style core. The same physical register also appears as a restricted supervisor alias. Two write ports update it. A write through the machine port may change only the machine-legal fields. A write through the supervisor port first merges its data into the word inside the supervisor window, and then passes through the same machine-level legalization. Both views are read combinationally from the registered word.

The extension-state field is not stored. It comes from a 2-bit input, `ext_state`. The dirty-summary bit in the top position is derived from the floating-point state and the extension state, and is never written. When a write alters any field that affects address translation, the block raises `xlat_flush` for one cycle so the translation caches can be invalidated. The floating-point unit can pulse `fp_dirty` to force its state field to dirty.

Top module: `status_word_unit`

## Requirements
- R1: A machine write (`m_wr_en`) replaces only these bits with `m_wr_data`: SIE 1, MIE 3, SPIE 5, MPIE 7, SPP 8, MPP 12:11, FS 14:13, MPRV 17, SUM 18, MXR 19, TVM 20 and TSR 22. The new value is visible on the read ports after the next rising clock edge.
- R2: `s_rd_data` equals `m_rd_data` masked to UIE 0, SIE 1, UPIE 4, SPIE 5, SPP 8, FS 14:13, XS 16:15, SUM 18, MXR 19 and SD 31. Every other bit reads zero.
- R3: A supervisor write (`s_wr_en` without `m_wr_en`) changes exactly the bits that are in both the supervisor window and the machine-legal set: SIE, SPIE, SPP, FS, SUM and MXR. UIE and UPIE stay zero.
- R4: Bit 31 (SD) of both read ports is 1 exactly when FS is 2'b11 or `ext_state` is 2'b11. It follows `ext_state` without any write.
- R5: `xlat_flush` is high for the single cycle after a clock edge at which a write changed any bit of MPP, MPRV, SUM or MXR. It is low after every other edge, including edges where a write left those bits unchanged.
- R6: A `fp_dirty` pulse makes FS read 2'b11 after the edge. This holds even when a write in the same cycle carries another FS value.
- R7: When both write enables are high in one cycle, only the machine write takes effect.
- R8: Synchronous active-high reset clears the stored word and `xlat_flush`. After reset, `m_rd_data` holds only `ext_state` at 16:15 and its SD bit. Stored bits hold their value in cycles with no write and no `fp_dirty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_wr_en | input | 1 | Machine-level write strobe |
| m_wr_data | input | 32 | Machine-level write value |
| s_wr_en | input | 1 | Supervisor-level write strobe |
| s_wr_data | input | 32 | Supervisor-level write value |
| fp_dirty | input | 1 | Floating-point unit marks its state dirty |
| ext_state | input | 2 | Extension-state field (XS), read live |
| m_rd_data | output | 32 | Machine view of the word |
| s_rd_data | output | 32 | Supervisor view of the word |
| xlat_flush | output | 1 | One-cycle translation-flush strobe |

## Verification
The hardest case to reach is a cycle in which the ports interact: a supervisor write lands together with a machine write or with `fp_dirty`, and the flush and FS results depend on who wins. Equally hard is a write that rewrites translation bits with their existing values, which must not flush. The bench drives these collisions directly, including all-ones supervisor data aimed at the UIE and UPIE bits. It then runs a long stretch of random simultaneous strobes and `ext_state` changes against a behavioural per-bit model that is compared every clock.

// File: rtl/stw_pkg.sv
package stw_pkg;
    localparam int WORD_W = 32;

    // field positions (RV32 layout)
    localparam int B_UIE  = 0;
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_UPIE = 4;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;
    localparam int B_FS   = 13;
    localparam int B_XS   = 15;
    localparam int B_MPRV = 17;
    localparam int B_SUM  = 18;
    localparam int B_MXR  = 19;
    localparam int B_TVM  = 20;
    localparam int B_TSR  = 22;
    localparam int B_SD   = WORD_W - 1;
    localparam int FLD2_W = 2;

    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] TWO = ONE | (ONE << 1);

    localparam logic [WORD_W-1:0] MACH_MASK =
        (ONE << B_SIE) | (ONE << B_MIE) | (ONE << B_SPIE) | (ONE << B_MPIE) |
        (ONE << B_SPP) | (TWO << B_MPP) | (TWO << B_FS)   | (ONE << B_MPRV) |
        (ONE << B_SUM) | (ONE << B_MXR) | (ONE << B_TVM)  | (ONE << B_TSR);

    localparam logic [WORD_W-1:0] SUP_MASK =
        (ONE << B_UIE) | (ONE << B_SIE) | (ONE << B_UPIE) | (ONE << B_SPIE) |
        (ONE << B_SPP) | (TWO << B_FS)  | (TWO << B_XS)   | (ONE << B_SUM)  |
        (ONE << B_MXR) | (ONE << B_SD);

    localparam logic [WORD_W-1:0] XLAT_MASK =
        (TWO << B_MPP) | (ONE << B_MPRV) | (ONE << B_SUM) | (ONE << B_MXR);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              flush;
    } stw_state_t;
endpackage

// File: rtl/stw_legalize.sv
module stw_legalize
    import stw_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic              m_en,
    input  logic [WORD_W-1:0] m_data,
    input  logic              s_en,
    input  logic [WORD_W-1:0] s_data,
    input  logic              fp_mark,
    output logic [WORD_W-1:0] nxt,
    output logic              xlat_changed
);
    logic [WORD_W-1:0] merged_s;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] legal;

    always_comb begin
        // supervisor data enters only inside its window
        merged_s = (cur & ~SUP_MASK) | (s_data & SUP_MASK);
        // machine port wins a collision
        src      = m_en ? m_data : merged_s;
        legal    = (cur & ~MACH_MASK) | (src & MACH_MASK);
        nxt      = (m_en || s_en) ? legal : cur;
        if (fp_mark) begin
            nxt[B_FS +: FLD2_W] = '1;
        end
        xlat_changed = |((nxt ^ cur) & XLAT_MASK);
    end
endmodule

// File: rtl/stw_view.sv
module stw_view
    import stw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [FLD2_W-1:0] xs,
    output logic [WORD_W-1:0] m_view,
    output logic [WORD_W-1:0] s_view
);
    logic dirty_sum;

    always_comb begin
        dirty_sum = (&word[B_FS +: FLD2_W]) || (&xs);
        m_view    = word & MACH_MASK;
        m_view[B_XS +: FLD2_W] = xs;
        m_view[B_SD] = dirty_sum;
        s_view    = m_view & SUP_MASK;
    end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              m_wr_en,
    input  logic [WORD_W-1:0] m_wr_data,
    input  logic              s_wr_en,
    input  logic [WORD_W-1:0] s_wr_data,
    input  logic              fp_dirty,
    input  logic [FLD2_W-1:0] ext_state,
    output logic [WORD_W-1:0] m_rd_data,
    output logic [WORD_W-1:0] s_rd_data,
    output logic              xlat_flush
);
    stw_state_t        st_d, st_q;
    logic [WORD_W-1:0] word_nxt;
    logic              xlat_chg;

    stw_legalize u_legal (
        .cur          (st_q.word),
        .m_en         (m_wr_en),
        .m_data       (m_wr_data),
        .s_en         (s_wr_en),
        .s_data       (s_wr_data),
        .fp_mark      (fp_dirty),
        .nxt          (word_nxt),
        .xlat_changed (xlat_chg)
    );

    stw_view u_view (
        .word   (st_q.word),
        .xs     (ext_state),
        .m_view (m_rd_data),
        .s_view (s_rd_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.word  = word_nxt;
        st_d.flush = xlat_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xlat_flush = st_q.flush;

    // R6
    fp_force_chk: assert property (@(posedge clk) disable iff (rst)
        fp_dirty |=> (m_rd_data[B_FS +: FLD2_W] == 2'b11));

    // R5
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        xlat_flush |-> $past(m_wr_en || s_wr_en));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!m_wr_en && !s_wr_en && !fp_dirty) |=> $stable(m_rd_data & MACH_MASK));

    // R2
    sup_window_chk: assert property (@(posedge clk) disable iff (rst)
        (s_rd_data & ~SUP_MASK) == '0);

    // R4
    sd_from_xs_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_state == 2'b11) |-> (s_rd_data[B_SD] && m_rd_data[B_SD]));

    // R7
    mach_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wr_en && s_wr_en && !fp_dirty) |=>
            ((m_rd_data & MACH_MASK) == ($past(m_wr_data) & MACH_MASK)));
endmodule

// File: tb/sim_status_word_unit.sv
`timescale 1ns/1ps
module sim_status_word_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_wr_en = 1'b0;
    logic [31:0] m_wr_data = '0;
    logic        s_wr_en = 1'b0;
    logic [31:0] s_wr_data = '0;
    logic        fp_dirty = 1'b0;
    logic [1:0]  ext_state = 2'b00;
    logic [31:0] m_rd_data, s_rd_data;
    logic        xlat_flush;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state: only bits a machine write may touch
    logic [31:0] mdl = '0;
    logic        mdl_flush = 1'b0;
    int mach_bits [14] = '{1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18, 19, 20, 22};
    int sup_bits  [12] = '{0, 1, 4, 5, 8, 13, 14, 15, 16, 18, 19, 31};
    int xlat_bits [5]  = '{11, 12, 17, 18, 19};

    status_word_unit u0 (
        .clk(clk), .rst(rst), .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
        .s_wr_en(s_wr_en), .s_wr_data(s_wr_data), .fp_dirty(fp_dirty),
        .ext_state(ext_state), .m_rd_data(m_rd_data), .s_rd_data(s_rd_data),
        .xlat_flush(xlat_flush)
    );

    always #2 clk = ~clk;

    function automatic bit in_sup(input int b);
        for (int i = 0; i < 12; i++) if (sup_bits[i] == b) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] em, es;
        em = mdl;
        em[16:15] = ext_state;
        em[31] = (mdl[14:13] == 2'b11) || (ext_state == 2'b11);
        es = '0;
        for (int i = 0; i < 12; i++) es[sup_bits[i]] = em[sup_bits[i]];
        tests++;
        if (m_rd_data !== em || s_rd_data !== es || xlat_flush !== mdl_flush) begin
            fails++;
            $display("FAIL %s: m=%h s=%h fl=%b expected m=%h s=%h fl=%b",
                     tag, m_rd_data, s_rd_data, xlat_flush, em, es, mdl_flush);
        end
    endtask

    task automatic step(input logic me, input logic [31:0] md, input logic se,
                        input logic [31:0] sd, input logic fp, input logic [1:0] xs,
                        input string tag);
        logic [31:0] old;
        m_wr_en = me; m_wr_data = md; s_wr_en = se; s_wr_data = sd;
        fp_dirty = fp; ext_state = xs;
        @(posedge clk);
        old = mdl;
        if (me) begin
            for (int i = 0; i < 14; i++) mdl[mach_bits[i]] = md[mach_bits[i]];
        end else if (se) begin
            for (int i = 0; i < 14; i++)
                if (in_sup(mach_bits[i])) mdl[mach_bits[i]] = sd[mach_bits[i]];
        end
        if (fp) mdl[14:13] = 2'b11;
        mdl_flush = 1'b0;
        for (int i = 0; i < 5; i++)
            if (old[xlat_bits[i]] != mdl[xlat_bits[i]]) mdl_flush = 1'b1;
        @(negedge clk);
        m_wr_en = 1'b0; s_wr_en = 1'b0; fp_dirty = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R8 reset");
        // R1 machine write all ones / zeros
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 2'b00, "R1 all ones");
        step(1, 32'h0000_0000, 0, 0, 0, 2'b00, "R1 all zeros");
        step(1, 32'hA5A5_5A5A, 0, 0, 0, 2'b01, "R1 pattern");
        // R8 idle hold
        step(0, 0, 0, 0, 0, 2'b01, "R8 idle");
        // R3 supervisor all ones: UIE/UPIE stay zero
        step(1, 0, 0, 0, 0, 2'b00, "R1 clear");
        step(0, 0, 1, 32'hFFFF_FFFF, 0, 2'b00, "R3 sup ones");
        step(0, 0, 1, 32'h0000_0000, 0, 2'b00, "R3 sup zeros");
        // R2 supervisor view masking with everything set
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 2'b10, "R2 view mask");
        // R4 SD from XS alone, then from FS
        step(1, 32'h0000_0000, 0, 0, 0, 2'b11, "R4 xs dirty");
        step(0, 0, 0, 0, 0, 2'b00, "R4 xs clean");
        step(1, 32'h0000_6000, 0, 0, 0, 2'b00, "R4 fs dirty");
        // R5 flush per field, and no flush on non-translation field
        step(1, 32'h0000_0000, 0, 0, 0, 2'b00, "R5 setup");
        step(1, 32'h0000_0800, 0, 0, 0, 2'b00, "R5 mpp");
        step(0, 0, 0, 0, 0, 2'b00, "R5 pulse ends");
        step(1, 32'h0002_0800, 0, 0, 0, 2'b00, "R5 mprv");
        step(0, 0, 1, 32'h0004_0000, 0, 2'b00, "R5 sum sup");
        step(0, 0, 1, 32'h000C_0000, 0, 2'b00, "R5 mxr sup");
        step(1, 32'h000E_0808, 0, 0, 0, 2'b00, "R5 mie only");
        step(1, 32'h000E_0808, 0, 0, 0, 2'b00, "R5 same value");
        // R6 fp dirty, including against a same-cycle write
        step(0, 0, 0, 0, 1, 2'b00, "R6 pulse");
        step(1, 32'h0000_0000, 0, 0, 1, 2'b00, "R6 vs mwrite");
        step(0, 0, 1, 32'h0000_2000, 1, 2'b00, "R6 vs swrite");
        // R7 collision
        step(1, 32'h0000_0002, 1, 32'h000C_0120, 0, 2'b00, "R7 collide");
        step(1, 32'h0008_0000, 1, 32'h0000_0000, 0, 2'b01, "R7 collide2");
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], $urandom, r[1], $urandom, r[2] & r[3], r[5:4],
                 "R1 R3 R5 R6 R7 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (R8 progress)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule